// File: doc/BRIEF.md
# Oversampled I2C Read-Only Target

This block is an I2C target that answers read requests from a bus master, and it runs entirely on the system clock. SCL and SDA are never used as clocks. Each line passes through a chain of system-clock flip-flops, and a one-cycle pulse marks each edge of the synchronized value. Those pulses only enable registers that the system clock already drives. START and STOP are found from SDA edges that occur while SCL is high.

After a START the target shifts in a 7-bit address followed by the direction bit. If the address matches `dev_addr` and the direction is read, it pulls SDA low for the ninth clock as its acknowledge. It then sends the 16-bit `word_in`, high byte first, each byte MSB-first, and lets go of SDA while the master acknowledges each byte. A master NACK after the first byte ends the transfer. After the second byte the target stays silent until the next START or STOP.

`word_in` is a plain level input with no handshake. It is captured on the SCL falling edge that closes the address acknowledge, and it may change freely at any other time. The bus is open-drain: `sda_oe` high means the target pulls SDA low, and low means it releases the line. The system clock is expected to run many times faster than SCL, which is nominally 100 kHz.

Top module: `i2c_read_target`

## Requirements
- R1: While reset is asserted and after it is released, `sda_oe` is low. The synchronizers reset to the idle-high bus level, so an idle bus after reset produces no edge pulse and no transfer.
- R2: SCL and SDA each pass through `SYNC_STAGES` (default 2) system-clock flip-flops with no logic between them. `sda_oe` reacts to a pin change after a fixed latency of `SYNC_STAGES` + 1 clocks (3 with the default).
- R3: START is the synchronized SDA falling while synchronized SCL is high, and STOP is SDA rising while SCL is high. A STOP aborts any transfer and releases SDA. A START, including a repeated START in the middle of a byte, restarts address reception.
- R4: Address bits are sampled on SCL rising edges, MSB first. The eighth bit is the direction bit, where 1 means read.
- R5: On an address match with direction 1, `sda_oe` goes high on the SCL falling edge after the eighth bit and stays high until the falling edge after the ninth bit, so the master reads ACK (0).
- R6: `sda_oe` changes only while synchronized SCL is low, so SDA is stable while SCL is high.
- R7: The data word is sent as bits 15..8 and then bits 7..0, each byte MSB-first. A 1 bit releases SDA and a 0 bit pulls it low.
- R8: SDA is released during each master acknowledge bit.
- R9: If the master NACKs the first byte (SDA high on the ninth clock), the target drives nothing more until the next START.
- R10: After the second byte the target releases SDA and drives nothing more until the next START, whatever the master's acknowledge was.
- R11: A non-matching address, or a matching address with direction 0, leaves SDA released through the acknowledge clock and all later clocks until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line as seen at the pad |
| sda_i | input | 1 | SDA line as seen at the pad |
| sda_oe | output | 1 | 1 = pull SDA low, 0 = release |
| dev_addr | input | ADDR_W (7) | Target address |
| word_in | input | DATA_W (16) | Word to return, captured when the address ACK ends |

## Verification
The bench builds the block with its defaults: a 7-bit address, a 16-bit word and two synchronizer stages. It runs SCL at 40 system clocks per period. At that ratio the three-cycle synchronizer and edge latency stays well inside each SCL phase, so a per-cycle reference model can predict `sda_oe` exactly. The same setup lets the bench place a repeated START or a STOP partway through a byte, and run extra clocks after a NACK or after the second byte to show that the target stays quiet.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_AACK,
    PH_SEND,
    PH_MACK,
    PH_HOLD
  } phase_t;
endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{RST_VAL}};
      prev  <= RST_VAL;
    end else begin
      chain <= {chain[STAGES-2:0], pin};
      prev  <= chain[STAGES-1];
    end
  end

  assign lvl  = chain[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/i2ct_ctrl.sv
module i2ct_ctrl
  import i2ct_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic [DATA_W-1:0] word_in,
  output logic              sda_oe,
  output phase_t            phase
);
  localparam int FRAME  = ADDR_W + 1;
  localparam int NBYTES = DATA_W / 8;
  localparam int CW     = $clog2(FRAME + 1);
  localparam int BYW    = $clog2(NBYTES + 1);

  logic [CW-1:0]     cnt;
  logic [BYW-1:0]    bytes;
  logic [ADDR_W:0]   rxsr;
  logic [DATA_W-1:0] txsr;
  logic              nack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      bytes  <= '0;
      rxsr   <= '0;
      txsr   <= '0;
      nack   <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start) begin
      phase  <= PH_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop) begin
      phase  <= PH_IDLE;
      sda_oe <= 1'b0;
    end else begin
      unique case (phase)
        PH_ADDR: begin
          if (scl_rise) begin
            rxsr <= {rxsr[ADDR_W-1:0], sda_lvl};
            cnt  <= cnt + 1'b1;
          end else if (scl_fall && cnt == CW'(FRAME)) begin
            if (rxsr == {dev_addr, 1'b1}) begin
              sda_oe <= 1'b1;
              phase  <= PH_AACK;
            end else begin
              phase <= PH_IDLE;
            end
          end
        end
        PH_AACK: begin
          if (scl_fall) begin
            txsr   <= word_in;
            sda_oe <= ~word_in[DATA_W-1];
            cnt    <= '0;
            bytes  <= '0;
            phase  <= PH_SEND;
          end
        end
        PH_SEND: begin
          if (scl_fall) begin
            txsr <= txsr << 1;
            if (cnt == CW'(7)) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              bytes  <= bytes + 1'b1;
              phase  <= PH_MACK;
            end else begin
              cnt    <= cnt + 1'b1;
              sda_oe <= ~txsr[DATA_W-2];
            end
          end
        end
        PH_MACK: begin
          if (scl_rise) begin
            nack <= sda_lvl;
          end else if (scl_fall) begin
            if (bytes == BYW'(NBYTES)) begin
              phase <= PH_HOLD;
            end else if (nack) begin
              phase <= PH_IDLE;
            end else begin
              sda_oe <= ~txsr[DATA_W-1];
              phase  <= PH_SEND;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_read_target.sv
module i2c_read_target
  import i2ct_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic [DATA_W-1:0] word_in
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] pins, lvls, rises, falls;
  logic   scl_lvl, sda_lvl, start_p, stop_p;
  phase_t phase;

  assign pins = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    i2ct_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (pins[g]),
      .lvl  (lvls[g]),
      .rise (rises[g]),
      .fall (falls[g])
    );
  end

  assign scl_lvl = lvls[0];
  assign sda_lvl = lvls[1];
  assign start_p = falls[1] & scl_lvl;
  assign stop_p  = rises[1] & scl_lvl;

  i2ct_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start_p),
    .stop    (stop_p),
    .scl_rise(rises[0]),
    .scl_fall(falls[0]),
    .sda_lvl (sda_lvl),
    .dev_addr(dev_addr),
    .word_in (word_in),
    .sda_oe  (sda_oe),
    .phase   (phase)
  );
endmodule

// File: rtl/i2ct_checker.sv
module i2ct_checker
  import i2ct_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   sda_oe,
  input logic   scl_lvl,
  input logic   start,
  input logic   stop,
  input phase_t phase
);
  a_r1_released_in_reset: assert property (@(posedge clk) !rst_n |-> !sda_oe);

  a_r3_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> phase == PH_ADDR);

  a_r3_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> phase == PH_IDLE && !sda_oe);

  a_r5_ack_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_AACK |-> sda_oe);

  a_r6_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_lvl);

  a_r8_release_master_ack: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_MACK |-> !sda_oe);

  // R9 R10 R11: quiet phases never pull the line
  a_r11_quiet_phases: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE || phase == PH_HOLD || phase == PH_ADDR) |-> !sda_oe);
endmodule

bind i2c_read_target i2ct_checker u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .sda_oe (sda_oe),
  .scl_lvl(scl_lvl),
  .start  (start_p),
  .stop   (stop_p),
  .phase  (phase)
);

// File: tb/i2c_read_target_bench.sv
`timescale 1ns/1ps
module i2c_read_target_bench;
  localparam logic [6:0] ADDR = 7'h52;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [15:0] word_in = 16'h0000;
  logic sda_oe;
  logic sda_bus;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_read_target u_i2c_read_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .dev_addr(ADDR), .word_in(word_in)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural reference, predicts sda_oe each cycle (R2 latency, R6)
  logic [3:0] sclh, sdah;
  logic [15:0] m_word;
  int m_st, m_n, m_a, m_i, m_sent;
  bit m_oe, m_nack;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclh = 4'hF; sdah = 4'hF; m_st = 0; m_oe = 0; m_n = 0; m_a = 0;
      m_i = 0; m_sent = 0; m_nack = 0; m_word = 0;
    end else begin
      bit r, f, sr, sf, sd;
      sclh = {sclh[2:0], scl_m};
      sdah = {sdah[2:0], sda_m & ~m_oe};
      r = sclh[2] & ~sclh[3]; f = ~sclh[2] & sclh[3];
      sr = sdah[2] & ~sdah[3]; sf = ~sdah[2] & sdah[3];
      sd = sdah[2];
      if (sf && sclh[2]) begin m_st = 1; m_n = 0; m_oe = 0; end
      else if (sr && sclh[2]) begin m_st = 0; m_oe = 0; end
      else case (m_st)
        1: if (r) begin m_a = ((m_a << 1) | sd) & 255; m_n++; end
           else if (f && m_n == 8) begin
             if (m_a == ADDR * 2 + 1) begin m_oe = 1; m_st = 2; end else m_st = 0;
           end
        2: if (f) begin m_word = word_in; m_i = 15; m_oe = !word_in[15]; m_sent = 0; m_st = 3; end
        3: if (f) begin
             m_sent++; m_i--;
             if (m_sent % 8 == 0) begin m_oe = 0; m_st = 4; end else m_oe = !m_word[m_i];
           end
        4: if (r) m_nack = sd;
           else if (f) begin
             if (m_sent >= 16) m_st = 5;
             else if (m_nack) m_st = 0;
             else begin m_oe = !m_word[m_i]; m_st = 3; end
           end
        default: ;
      endcase
    end
  end

  always @(negedge clk)
    if (rst_n && !done) chk(sda_oe == m_oe, "R2 R6 cycle model", sda_oe, m_oe);

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic m_start;
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
  endtask
  task automatic m_stop;
    sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(Q);
  endtask
  task automatic m_wbit(input bit b, output bit oe_seen);
    sda_m = b; tick(Q); scl_m = 1; tick(Q); oe_seen = sda_oe; tick(Q); scl_m = 0; tick(Q);
  endtask
  task automatic m_rbit(output bit b);
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); b = sda_bus; tick(Q); scl_m = 0; tick(Q);
  endtask
  task automatic m_wbyte(input logic [7:0] v);
    bit d;
    for (int k = 7; k >= 0; k--) m_wbit(v[k], d);
  endtask
  task automatic m_rbyte(output logic [7:0] v);
    bit b;
    for (int k = 7; k >= 0; k--) begin m_rbit(b); v[k] = b; end
  endtask

  initial begin
    logic [7:0] hi, lo, x;
    bit ack, oe_seen, b;
    tick(5);
    chk(sda_oe == 0, "R1 in reset", sda_oe, 0);
    rst_n = 1; tick(20);
    chk(sda_oe == 0, "R1 after reset", sda_oe, 0);

    // normal read, MSB-first address (R4) and data (R7)
    word_in = 16'hC35A;
    m_start; m_wbyte({ADDR, 1'b1}); m_rbit(ack);
    chk(ack == 0, "R5 R4 address ack", ack, 0);
    m_rbyte(hi);
    chk(hi == 8'hC3, "R7 high byte", hi, 8'hC3);
    m_wbit(0, oe_seen);
    chk(oe_seen == 0, "R8 released in master ack", oe_seen, 0);
    m_rbyte(lo);
    chk(lo == 8'h5A, "R7 low byte", lo, 8'h5A);
    m_wbit(1, oe_seen); m_stop; tick(20);

    // wrong address
    m_start; m_wbyte({ADDR ^ 7'h01, 1'b1}); m_rbit(ack);
    chk(ack == 1, "R11 wrong address no ack", ack, 1);
    m_rbyte(x);
    chk(x == 8'hFF, "R11 wrong address silent", x, 8'hFF);
    m_stop;

    // matching address, write direction
    m_start; m_wbyte({ADDR, 1'b0}); m_rbit(ack);
    chk(ack == 1, "R11 write no ack", ack, 1);
    m_stop;

    // NACK after first byte
    word_in = 16'h0F0F;
    m_start; m_wbyte({ADDR, 1'b1}); m_rbit(ack); m_rbyte(hi);
    chk(hi == 8'h0F, "R7 first byte before nack", hi, 8'h0F);
    m_wbit(1, oe_seen); m_rbyte(x);
    chk(x == 8'hFF, "R9 silent after nack", x, 8'hFF);
    m_stop;

    // ACK on second byte, then extra clocks
    word_in = 16'h8001;
    m_start; m_wbyte({ADDR, 1'b1}); m_rbit(ack); m_rbyte(hi); m_wbit(0, oe_seen);
    m_rbyte(lo);
    chk(lo == 8'h01, "R7 second byte", lo, 8'h01);
    m_wbit(0, oe_seen); m_rbyte(x);
    chk(x == 8'hFF, "R10 silent after two bytes", x, 8'hFF);
    m_stop;

    // repeated START mid-byte (bit 12 is 1 so the line is free)
    word_in = 16'h1A5C;
    m_start; m_wbyte({ADDR, 1'b1}); m_rbit(ack);
    for (int k = 0; k < 3; k++) m_rbit(b);
    word_in = 16'h6E21;
    m_start; m_wbyte({ADDR, 1'b1}); m_rbit(ack);
    chk(ack == 0, "R3 repeated start ack", ack, 0);
    m_rbyte(hi); m_wbit(0, oe_seen); m_rbyte(lo);
    chk({hi, lo} == 16'h6E21, "R3 data after repeated start", {hi, lo}, 16'h6E21);
    m_wbit(1, oe_seen); m_stop;

    // STOP in the middle of the address
    m_start;
    for (int k = 0; k < 4; k++) m_wbit(k[0], oe_seen);
    m_stop; tick(Q);
    scl_m = 0; tick(Q);
    m_rbyte(x); m_rbit(ack);
    chk({x, ack} == 9'h1FF, "R3 stop aborts address", {x, ack}, 9'h1FF);
    sda_m = 1; scl_m = 1; tick(20);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    done = 1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule